// File: doc/BRIEF.md
# Memory Operation Admission and Ordering Unit

This block sits at the dispatch point of an out-of-order core. It receives the memory properties of each instruction: whether it may read memory, whether it may write memory, and whether it has side effects. In the same cycle it reports whether the load queue and the store queue have room for the instruction. When they do, it admits the instruction, gives it a fresh dependency group number, and raises up to four edge requests to a downstream group tracker. Each edge request names an older group that the new group has to wait for.

An instruction that may read memory and has side effects acts as a load barrier. One that may write memory and has side effects acts as a store barrier. One with both properties is both barriers at once. The unit keeps the most recent store, load, load-barrier and store-barrier group numbers, and uses them to build the edges. It also keeps the occupancy of both queues. A load entry is freed when the load retires. A store entry is freed when the store commits. A configuration input selects no-alias mode, in which loads may overtake older stores.

Top module: `ordq_admit`

## Requirements
- R1: `disp_status` reads 0 when the instruction fits, 1 when it may read and the load queue is full, and 2 when it may write and the store queue is full. When both queues block the instruction the result is 1. An instruction with neither memory flag always gets 0 and is never accepted.
- R2: A queue size parameter of 0 makes that queue unbounded, so it never reports full. A nonzero size reports full exactly when the used count equals the size.
- R3: An accepted instruction that may read takes one load entry. An accepted instruction that may write takes one store entry. `lq_used` and `sq_used` show the new counts one cycle after the acceptance.
- R4: A dispatch with a nonzero status is rejected. `disp_accept` stays 0, neither count changes, and the next accepted instruction receives the group number the rejected one would have received.
- R5: Accepted instructions receive group numbers 1, 2, 3 and so on. After the largest value that fits in GW bits, the next number is 1, so 0 is never used. `disp_gid` reads 0 whenever no instruction is accepted.
- R6: An accepted instruction that may write raises edge 0 from the latest store group and edge 1 from the latest load group, in either mode. Edge k is `edge_valid[k]` with its source on `edge_src[k*GW +: GW]`.
- R7: An accepted instruction that may read but not write raises edge 0 from the latest store group only when `cfg_no_alias` is 0. A plain load never raises edge 1, so loads may overtake older loads.
- R8: An accepted instruction that may read raises edge 2 from the latest load-barrier group. One that may write raises edge 3 from the latest store-barrier group. A load barrier also raises edge 1 from the latest load group.
- R9: `ld_retire` frees one load entry and `st_commit` frees one store entry, one cycle later. An acquisition and a release of the same queue in the same cycle leave its count unchanged.
- R10: A release on a queue whose count is 0 is ignored, and it sets `rel_err`. `rel_err` stays set until reset.
- R11: After reset both counts are 0, `rel_err` is 0, no latest group is recorded (so no edge is raised), and the next group number is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_no_alias | input | 1 | 1: loads may overtake older stores |
| disp_valid | input | 1 | An instruction is offered for dispatch |
| disp_ld | input | 1 | The instruction may read memory |
| disp_st | input | 1 | The instruction may write memory |
| disp_se | input | 1 | The instruction has side effects |
| disp_status | output | 2 | Admission status, as encoded in R1 |
| disp_accept | output | 1 | The memory instruction is admitted this cycle |
| disp_gid | output | GW | Group number given to the admitted instruction, 0 if none |
| edge_valid | output | 4 | Edge request valid, one bit per edge slot |
| edge_src | output | 4*GW | Source group of each edge slot |
| ld_retire | input | 1 | A load retired, so one load entry is freed |
| st_commit | input | 1 | A store committed, so one store entry is freed |
| lq_used | output | CW | Load queue occupancy |
| sq_used | output | CW | Store queue occupancy |
| rel_err | output | 1 | Sticky flag: a release arrived on an empty queue |

## Verification
The assertions assume the environment keeps the dispatch flags stable while `disp_valid` is high within a cycle. They also assume a count never has to pass the largest value CW bits can hold, which only an unbounded queue could reach. The stimulus stays within the queue sizes, and the unbounded instance receives only a handful of loads. Releases on empty queues are sent deliberately, so the sticky-flag property has to hold across many cycles that follow.

// File: rtl/ordq_pkg.sv
package ordq_pkg;

  localparam logic [1:0] ST_OK      = 2'd0;
  localparam logic [1:0] ST_LQ_FULL = 2'd1;
  localparam logic [1:0] ST_SQ_FULL = 2'd2;

  // A bounded queue is full when every slot is in use; size 0 is unbounded
  function automatic logic q_full(input int unsigned used, input int unsigned size);
    return (size != 0) && (used == size);
  endfunction

  // Load-side blocking takes priority over store-side blocking
  function automatic logic [1:0] admit_status(input logic ld, input logic st,
                                              input logic lq_full, input logic sq_full);
    if (ld && lq_full) return ST_LQ_FULL;
    if (st && sq_full) return ST_SQ_FULL;
    return ST_OK;
  endfunction

endpackage

// File: rtl/ordq_occ.sv
module ordq_occ #(
  parameter int unsigned SIZE = 4,
  parameter int unsigned CW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acq,
  input  logic          rel,
  output logic [CW-1:0] used,
  output logic          full,
  output logic          rel_on_empty
);
  localparam logic [CW-1:0] CNT_TOP = '1;

  logic acq_ok;
  logic rel_ok;

  assign full         = ordq_pkg::q_full(32'(used), SIZE);
  assign rel_ok       = rel && (used != '0);
  assign rel_on_empty = rel && (used == '0);
  assign acq_ok       = acq && (used != CNT_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used <= '0;
    end else begin
      case ({acq_ok, rel_ok})
        2'b10:   used <= used + 1'b1;
        2'b01:   used <= used - 1'b1;
        default: used <= used;
      endcase
    end
  end
endmodule

// File: rtl/ordq_grp.sv
module ordq_grp #(
  parameter int unsigned GW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc,
  input  logic            is_ld,
  input  logic            is_st,
  input  logic            is_se,
  input  logic            no_alias,
  output logic [GW-1:0]   new_id,
  output logic [3:0]      edge_valid,
  output logic [4*GW-1:0] edge_src
);
  localparam int unsigned NSLOT = 4;
  localparam logic [GW-1:0] GID_TOP = '1;

  // Slot roles: 0 latest store, 1 latest load, 2 latest load barrier, 3 latest store barrier
  function automatic logic [GW-1:0] gid_after(input logic [GW-1:0] g);
    return (g == GID_TOP) ? GW'(1) : g + 1'b1;
  endfunction

  logic [GW-1:0] nid_q;
  logic [GW-1:0] last_q [NSLOT];
  logic [NSLOT-1:0] want;
  logic [NSLOT-1:0] upd;
  logic lbar;
  logic sbar;

  assign lbar = is_ld && is_se;
  assign sbar = is_st && is_se;

  assign want[0] = is_st || (is_ld && !no_alias);
  assign want[1] = is_st || lbar;
  assign want[2] = is_ld;
  assign want[3] = is_st;

  assign upd[0] = is_st;
  assign upd[1] = is_ld;
  assign upd[2] = lbar;
  assign upd[3] = sbar;

  assign new_id = acc ? nid_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)   nid_q <= GW'(1);
    else if (acc) nid_q <= gid_after(nid_q);
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    assign edge_valid[k]          = acc && want[k] && (last_q[k] != '0);
    assign edge_src[k*GW +: GW]   = last_q[k];

    always_ff @(posedge clk) begin
      if (!rst_n)             last_q[k] <= '0;
      else if (acc && upd[k]) last_q[k] <= nid_q;
    end
  end
endmodule

// File: rtl/ordq_admit.sv
module ordq_admit #(
  parameter int unsigned LQ_SIZE = 4,
  parameter int unsigned SQ_SIZE = 3,
  parameter int unsigned CW      = 4,
  parameter int unsigned GW      = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_no_alias,
  input  logic            disp_valid,
  input  logic            disp_ld,
  input  logic            disp_st,
  input  logic            disp_se,
  output logic [1:0]      disp_status,
  output logic            disp_accept,
  output logic [GW-1:0]   disp_gid,
  output logic [3:0]      edge_valid,
  output logic [4*GW-1:0] edge_src,
  input  logic            ld_retire,
  input  logic            st_commit,
  output logic [CW-1:0]   lq_used,
  output logic [CW-1:0]   sq_used,
  output logic            rel_err
);
  logic lq_full;
  logic sq_full;
  logic lq_bad_rel;
  logic sq_bad_rel;
  logic is_mem;
  logic acc;

  assign is_mem      = disp_ld || disp_st;
  assign disp_status = ordq_pkg::admit_status(disp_ld, disp_st, lq_full, sq_full);
  assign acc         = disp_valid && is_mem && (disp_status == ordq_pkg::ST_OK);
  assign disp_accept = acc;

  ordq_occ #(.SIZE(LQ_SIZE), .CW(CW)) u_lq (
    .clk(clk), .rst_n(rst_n), .acq(acc && disp_ld), .rel(ld_retire),
    .used(lq_used), .full(lq_full), .rel_on_empty(lq_bad_rel)
  );

  ordq_occ #(.SIZE(SQ_SIZE), .CW(CW)) u_sq (
    .clk(clk), .rst_n(rst_n), .acq(acc && disp_st), .rel(st_commit),
    .used(sq_used), .full(sq_full), .rel_on_empty(sq_bad_rel)
  );

  ordq_grp #(.GW(GW)) u_grp (
    .clk(clk), .rst_n(rst_n), .acc(acc), .is_ld(disp_ld), .is_st(disp_st),
    .is_se(disp_se), .no_alias(cfg_no_alias), .new_id(disp_gid),
    .edge_valid(edge_valid), .edge_src(edge_src)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                       rel_err <= 1'b0;
    else if (lq_bad_rel || sq_bad_rel) rel_err <= 1'b1;
  end
endmodule

// File: rtl/ordq_admit_chk.sv
module ordq_admit_chk #(
  parameter int unsigned LQ_SIZE = 4,
  parameter int unsigned SQ_SIZE = 3,
  parameter int unsigned CW      = 4,
  parameter int unsigned GW      = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          disp_valid,
  input logic          disp_ld,
  input logic          disp_st,
  input logic          disp_se,
  input logic [1:0]    disp_status,
  input logic          disp_accept,
  input logic [GW-1:0] disp_gid,
  input logic [3:0]    edge_valid,
  input logic          ld_retire,
  input logic          st_commit,
  input logic [CW-1:0] lq_used,
  input logic [CW-1:0] sq_used,
  input logic          rel_err
);
  logic lq_at_cap;
  logic sq_at_cap;
  assign lq_at_cap = (LQ_SIZE != 0) && (lq_used == CW'(LQ_SIZE));
  assign sq_at_cap = (SQ_SIZE != 0) && (sq_used == CW'(SQ_SIZE));

  // R1
  status_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_ld && disp_st && lq_at_cap && sq_at_cap) |-> (disp_status == 2'd1));

  // R4
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_status != 2'd0 && !ld_retire && !st_commit)
      |=> ($stable(lq_used) && $stable(sq_used)));

  // R5
  gid_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_accept |-> (disp_gid != '0));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (LQ_SIZE != 0) |-> (lq_used <= CW'(LQ_SIZE)));

  // R3
  acq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_accept && disp_ld && !ld_retire && !lq_at_cap)
      |=> (lq_used == CW'($past(lq_used) + 1'b1)));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err |=> rel_err);

  // R6
  edge_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_valid != 4'd0) |-> disp_accept);

  // R7
  load_no_load_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_accept && disp_ld && !disp_st && !disp_se) |-> !edge_valid[1]);

  // R9
  store_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_commit && !disp_accept && sq_used != '0 && !sq_at_cap)
      |=> (sq_used == CW'($past(sq_used) - 1'b1)));
endmodule

bind ordq_admit ordq_admit_chk #(
  .LQ_SIZE(LQ_SIZE), .SQ_SIZE(SQ_SIZE), .CW(CW), .GW(GW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ld(disp_ld),
  .disp_st(disp_st), .disp_se(disp_se), .disp_status(disp_status),
  .disp_accept(disp_accept), .disp_gid(disp_gid), .edge_valid(edge_valid),
  .ld_retire(ld_retire), .st_commit(st_commit), .lq_used(lq_used),
  .sq_used(sq_used), .rel_err(rel_err)
);

// File: tb/ordq_admit_bench.sv
module ordq_admit_bench;
  localparam int CLK_P = 10;
  localparam int LQ = 4;
  localparam int SQ = 3;
  localparam int CW = 4;
  localparam int GW = 4;
  localparam int GMAX = (1 << GW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic na = 1'b0, v = 1'b0, ld = 1'b0, st = 1'b0, se = 1'b0, ret = 1'b0, com = 1'b0;

  logic [1:0]      status, u_status;
  logic            accept, u_accept;
  logic [GW-1:0]   gid, u_gid;
  logic [3:0]      ev, u_ev;
  logic [4*GW-1:0] es, u_es;
  logic [CW-1:0]   lqu, squ, u_lqu, u_squ;
  logic            err, u_err;

  always #(CLK_P/2) clk = ~clk;

  ordq_admit #(.LQ_SIZE(LQ), .SQ_SIZE(SQ), .CW(CW), .GW(GW)) u_ordq_admit (
    .clk(clk), .rst_n(rst_n), .cfg_no_alias(na), .disp_valid(v), .disp_ld(ld),
    .disp_st(st), .disp_se(se), .disp_status(status), .disp_accept(accept),
    .disp_gid(gid), .edge_valid(ev), .edge_src(es), .ld_retire(ret),
    .st_commit(com), .lq_used(lqu), .sq_used(squ), .rel_err(err)
  );

  // Same stimulus, both queues unbounded
  ordq_admit #(.LQ_SIZE(0), .SQ_SIZE(0), .CW(CW), .GW(GW)) u_ordq_admit_unb (
    .clk(clk), .rst_n(rst_n), .cfg_no_alias(na), .disp_valid(v), .disp_ld(ld),
    .disp_st(st), .disp_se(se), .disp_status(u_status), .disp_accept(u_accept),
    .disp_gid(u_gid), .edge_valid(u_ev), .edge_src(u_es), .ld_retire(ret),
    .st_commit(com), .lq_used(u_lqu), .sq_used(u_squ), .rel_err(u_err)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Reference state: counts, latest groups (store, load, load barrier, store barrier)
  int m_lq, m_sq, m_nid;
  int m_last [4];
  bit m_err;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lq = 0; m_sq = 0; m_nid = 1; m_err = 0;
    foreach (m_last[i]) m_last[i] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; v = 0; ld = 0; st = 0; se = 0; ret = 0; com = 0; na = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  // One dispatch cycle; expected values come from the requirement rules
  task automatic step(input logic i_ld, input logic i_st, input logic i_se,
                      input logic i_na, input logic i_ret, input logic i_com,
                      input int exp_status);
    int e_status;
    bit e_acc;
    bit e_v [4];
    bit lq_full, sq_full;
    @(negedge clk);
    v = 1'b1; ld = i_ld; st = i_st; se = i_se; na = i_na; ret = i_ret; com = i_com;
    #1;
    lq_full = (m_lq >= LQ);
    sq_full = (m_sq >= SQ);
    if (i_ld && lq_full)      e_status = 1;
    else if (i_st && sq_full) e_status = 2;
    else                      e_status = 0;
    e_acc = (i_ld || i_st) && (e_status == 0);
    // R7 load after store depends on alias mode; R6 store after store and load
    e_v[0] = e_acc && m_last[0] != 0 && (i_st || !i_na);
    e_v[1] = e_acc && m_last[1] != 0 && (i_st || (i_ld && i_se));
    // R8 barrier edges
    e_v[2] = e_acc && m_last[2] != 0 && i_ld;
    e_v[3] = e_acc && m_last[3] != 0 && i_st;
    chk("R1 status", int'(status), e_status);
    if (exp_status >= 0) chk("R1 table status", int'(status), exp_status);
    chk("R4 accept", int'(accept), int'(e_acc));
    chk("R5 gid", int'(gid), e_acc ? m_nid : 0);
    chk("R7 edge0 valid", int'(ev[0]), int'(e_v[0]));
    chk("R6 edge1 valid", int'(ev[1]), int'(e_v[1]));
    chk("R8 edge2 valid", int'(ev[2]), int'(e_v[2]));
    chk("R8 edge3 valid", int'(ev[3]), int'(e_v[3]));
    for (int k = 0; k < 4; k++)
      if (e_v[k]) chk("R6 edge source", int'(es[k*GW +: GW]), m_last[k]);
    @(posedge clk);
    if (i_ret && m_lq == 0) m_err = 1;
    if (i_com && m_sq == 0) m_err = 1;
    if (i_ret && m_lq != 0) m_lq--;
    if (i_com && m_sq != 0) m_sq--;
    if (e_acc) begin
      if (i_ld) m_lq++;
      if (i_st) m_sq++;
      if (i_st) m_last[0] = m_nid;
      if (i_ld) m_last[1] = m_nid;
      if (i_ld && i_se) m_last[2] = m_nid;
      if (i_st && i_se) m_last[3] = m_nid;
      m_nid = (m_nid == GMAX) ? 1 : m_nid + 1;
    end
    #1;
    chk("R3 lq_used", int'(lqu), m_lq);
    chk("R9 sq_used", int'(squ), m_sq);
    chk("R10 rel_err", int'(err), int'(m_err));
  endtask

  task automatic idle();
    @(negedge clk);
    v = 0; ld = 0; st = 0; se = 0; ret = 0; com = 0;
  endtask

  // Row: [7]ld [6]st [5]side effect [4]no_alias [3]retire [2]commit [1:0]expected status
  localparam int NVEC = 15;
  localparam logic [7:0] VEC [NVEC] = '{
    8'b1000_0000, 8'b0100_0000, 8'b1000_0000, 8'b1001_0000, 8'b1010_0000,
    8'b1000_0001, 8'b0100_0000, 8'b1100_0001, 8'b0000_1000, 8'b0110_0000,
    8'b0100_0010, 8'b1001_0000, 8'b1100_0001, 8'b0000_1100, 8'b0100_0000
  };

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    // R11 reset state
    chk("R11 lq_used after reset", int'(lqu), 0);
    chk("R11 sq_used after reset", int'(squ), 0);
    chk("R11 rel_err after reset", int'(err), 0);

    for (int i = 0; i < NVEC; i++)
      step(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2],
           int'(VEC[i][1:0]));
    idle();

    // R10 release on empty queue, then flag holds until reset
    do_reset();
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    chk("R10 flag stays set", int'(err), 1);
    idle();
    do_reset();
    #1;
    chk("R11 rel_err cleared by reset", int'(err), 0);

    // R5 and R9: group number wrap with load acquire and retire in one cycle
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0);
    for (int i = 0; i < GMAX - 1; i++)
      step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 0);
    @(negedge clk);
    v = 1; ld = 1; st = 0; se = 0; na = 1; ret = 1; com = 0;
    #1;
    chk("R5 gid wraps to 1", int'(gid), 1);
    @(posedge clk);
    #1;
    chk("R9 net zero count", int'(lqu), 1);
    idle();

    // R2 unbounded queues never fill
    do_reset();
    for (int i = 0; i < 6; i++)
      step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, -1);
    @(negedge clk);
    v = 1; ld = 1; st = 1; se = 0; na = 1; ret = 0; com = 0;
    #1;
    chk("R2 unbounded status", int'(u_status), 0);
    chk("R2 unbounded lq_used", int'(u_lqu), 6);
    chk("R1 bounded load full", int'(status), 1);
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule